// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block is a calendar clock core. It holds seconds, minutes, hours, day of month, month, two-digit year and weekday, each as one packed-BCD byte. A one-second tick input advances the time while the run bit in the control byte is set. A host reaches every field and the control and status bytes through a simple byte-wide register port with an address, write data, a write strobe and combinational read data.

A coherent multi-byte read works like this. The host writes the snapshot bit, and the core copies the six date and time counters into a static shadow bank. Later reads of those addresses return the frozen copy, so a carry that lands between two byte reads cannot tear the value. To set the time, the host clears the run bit, writes the fields and sets run again.

Each of the remaining control bits does one job. One selects a 12-hour hour format with an afternoon flag. One rounds the time to the nearest minute. The status byte mirrors whether the clock is running.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the time is 00:00:00, day 01, month 01, year 00, weekday 0. The control byte (0x0D) reads 0x00 (stopped), and the status byte (0x0E) reads 0x00.
- R2: The fields sit at these addresses, each as a packed-BCD byte: seconds 0x00, minutes 0x01, hours 0x02, day 0x03, month 0x04, year 0x05, weekday 0x06. A write to a field loads it at that clock edge, and it wins over a tick that arrives in the same cycle.
- R3: With control bit 0 at 1, each cycle with the tick high advances the time by one second. With bit 0 at 0, ticks are ignored. Status bit 1 reads the value of control bit 0.
- R4: In 24-hour mode (control bit 3 at 0), seconds and minutes roll from 59 to 00 and carry onward. Hours run 00 to 23, and 23:59:59 rolls to 00:00:00 with a carry into the day.
- R5: In 12-hour mode (control bit 3 at 1), the hour byte holds the afternoon flag in bit 7 and BCD 01 to 12 in bits 5:0. 11:59:59 rolls to 12:00:00 with the flag toggled, 12 rolls to 01 with the flag kept, and 11:59:59 with the flag set rolls to 12 with the flag clear and carries into the day.
- R6: The day wraps to 01 after the last day of the month. April, June, September and November have 30 days. February has 29 days when the year is a multiple of 4 (00 included) and 28 otherwise. All other months have 31.
- R7: Month 12 wraps to 01 and carries into the year. Year 99 wraps to 00.
- R8: The weekday counts 0 to 6, steps on every day carry, and wraps from 6 to 0.
- R9: Writing the control byte with bit 6 set copies seconds through year into the shadow bank at that edge. Reads of 0x00 to 0x05 always return the shadow bank, which changes at no other time. A read of 0x06 returns the live weekday.
- R10: Control bit 6 reads 1 in the cycle after a write that sets it and 0 afterwards. A write setting bit 6 while it still reads 1 takes no new snapshot.
- R11: Writing the control byte with bit 1 set zeroes the seconds. When the seconds were 30 or more, it also advances the minute with full carry. This works whether or not the clock runs, a tick in that cycle is dropped, and bit 1 always reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1s | input | 1 | One-cycle pulse per elapsed second |
| bus_addr | input | 5 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |

## Verification
On every cycle, the assertions check four things: a stopped clock with no bus write holds its counters, the shadow bank moves only on a snapshot write, seconds wrap from 59 to 00, and the noon and year-end transitions roll correctly. Month lengths across leap and common years, the weekday wrap, the rounding carry, the self-clearing snapshot bit and a write racing a tick can only be shown by the bench's directed and random scenarios. The bench compares those scenarios against a binary calendar model.

// File: rtl/bcd_rtc_pkg.sv
package bcd_rtc_pkg;

    localparam int FIELD_W       = 8;
    localparam int NUM_FIELDS    = 7;
    localparam int SHADOW_FIELDS = 6;
    localparam int REG_ADDR_W    = 5;

    typedef logic [FIELD_W-1:0]    bcd8_t;
    typedef logic [REG_ADDR_W-1:0] reg_addr_t;
    typedef logic [NUM_FIELDS-1:0][FIELD_W-1:0] time_bytes_t;

    // Field order gives byte index == register address (seconds in byte 0)
    typedef struct packed {
        bcd8_t wday;
        bcd8_t year;
        bcd8_t mon;
        bcd8_t day;
        bcd8_t hour;
        bcd8_t min;
        bcd8_t sec;
    } rtc_time_t;

    localparam reg_addr_t A_CTRL = 5'h0D;
    localparam reg_addr_t A_STAT = 5'h0E;

    localparam int CB_RUN   = 0;
    localparam int CB_ROUND = 1;
    localparam int CB_H12   = 3;
    localparam int CB_SNAP  = 6;
    localparam int SB_RUN   = 1;

    localparam bcd8_t CTRL_KEEP = ~((bcd8_t'(1) << CB_ROUND) | (bcd8_t'(1) << CB_SNAP));
    localparam bcd8_t WDAY_LAST = 8'h06;

    localparam rtc_time_t RESET_TIME = '{wday: 8'h00, year: 8'h00, mon: 8'h01,
                                         day: 8'h01, hour: 8'h00, min: 8'h00,
                                         sec: 8'h00};

    function automatic bcd8_t bcd_inc(bcd8_t v);
        if (v[3:0] >= 4'h9) return {v[7:4] + 4'h1, 4'h0};
        return {v[7:4], v[3:0] + 4'h1};
    endfunction

    // Multiple of four in BCD: even tens -> units 0/4/8, odd tens -> units 2/6
    function automatic logic year_is_leap(bcd8_t y);
        if (!y[4]) return (y[3:0] == 4'h0) || (y[3:0] == 4'h4) || (y[3:0] == 4'h8);
        return (y[3:0] == 4'h2) || (y[3:0] == 4'h6);
    endfunction

    function automatic bcd8_t month_len(bcd8_t m, bcd8_t y);
        case (m)
            8'h02:                      return year_is_leap(y) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/bcd_rtc_advance.sv
module bcd_rtc_advance
    import bcd_rtc_pkg::*;
(
    input  rtc_time_t cur,
    input  logic      mode12,
    input  logic      sec_step,
    input  logic      round_min,
    output rtc_time_t nxt
);

    logic  c_min, c_hr, c_day, c_mon, c_yr;
    bcd8_t hr_inc;

    always_comb begin
        nxt    = cur;
        c_min  = 1'b0;
        c_hr   = 1'b0;
        c_day  = 1'b0;
        c_mon  = 1'b0;
        c_yr   = 1'b0;
        hr_inc = bcd_inc({2'b00, cur.hour[5:0]});

        // rounding owns the seconds field in its cycle; the tick is dropped
        if (round_min) begin
            c_min   = (cur.sec >= 8'h30);
            nxt.sec = 8'h00;
        end else if (sec_step) begin
            if (cur.sec >= 8'h59) begin
                nxt.sec = 8'h00;
                c_min   = 1'b1;
            end else begin
                nxt.sec = bcd_inc(cur.sec);
            end
        end

        if (c_min) begin
            if (cur.min >= 8'h59) begin
                nxt.min = 8'h00;
                c_hr    = 1'b1;
            end else begin
                nxt.min = bcd_inc(cur.min);
            end
        end

        if (c_hr) begin
            if (mode12) begin
                if (cur.hour[5:0] >= 6'h12) begin
                    nxt.hour = {cur.hour[7], 7'h01};
                end else if (cur.hour[5:0] == 6'h11) begin
                    nxt.hour = {~cur.hour[7], 7'h12};
                    c_day    = cur.hour[7];
                end else begin
                    nxt.hour = {cur.hour[7], 1'b0, hr_inc[5:0]};
                end
            end else if (cur.hour >= 8'h23) begin
                nxt.hour = 8'h00;
                c_day    = 1'b1;
            end else begin
                nxt.hour = bcd_inc(cur.hour);
            end
        end

        if (c_day) begin
            nxt.wday = (cur.wday >= WDAY_LAST) ? 8'h00 : cur.wday + 8'h01;
            if (cur.day >= month_len(cur.mon, cur.year)) begin
                nxt.day = 8'h01;
                c_mon   = 1'b1;
            end else begin
                nxt.day = bcd_inc(cur.day);
            end
        end

        if (c_mon) begin
            if (cur.mon >= 8'h12) begin
                nxt.mon = 8'h01;
                c_yr    = 1'b1;
            end else begin
                nxt.mon = bcd_inc(cur.mon);
            end
        end

        if (c_yr) nxt.year = (cur.year >= 8'h99) ? 8'h00 : bcd_inc(cur.year);
    end

endmodule

// File: rtl/bcd_rtc_shadow.sv
module bcd_rtc_shadow
    import bcd_rtc_pkg::*;
(
    input  logic                                      clk,
    input  logic                                      rst,
    input  logic                                      capture,
    input  logic [SHADOW_FIELDS-1:0][FIELD_W-1:0]     live,
    output logic [SHADOW_FIELDS-1:0][FIELD_W-1:0]     held
);

    localparam time_bytes_t RESET_BYTES = RESET_TIME;

    for (genvar i = 0; i < SHADOW_FIELDS; i++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst)          held[i] <= RESET_BYTES[i];
            else if (capture) held[i] <= live[i];
        end
    end

endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
    import bcd_rtc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick_1s,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [FIELD_W-1:0]    bus_wdata,
    input  logic                  bus_we,
    output logic [FIELD_W-1:0]    bus_rdata
);

    time_bytes_t live_q;
    rtc_time_t   live_nxt;
    logic [SHADOW_FIELDS-1:0][FIELD_W-1:0] shadow_q;
    bcd8_t       ctrl_q;
    logic        snap_q;

    logic wr_ctrl, wr_time, snap_take, round_req;

    assign wr_ctrl   = bus_we && (bus_addr == A_CTRL);
    assign wr_time   = bus_we && (bus_addr < reg_addr_t'(NUM_FIELDS));
    assign snap_take = wr_ctrl && bus_wdata[CB_SNAP] && !snap_q;
    assign round_req = wr_ctrl && bus_wdata[CB_ROUND];

    bcd_rtc_advance u_adv (
        .cur       (live_q),
        .mode12    (ctrl_q[CB_H12]),
        .sec_step  (tick_1s && ctrl_q[CB_RUN]),
        .round_min (round_req),
        .nxt       (live_nxt)
    );

    bcd_rtc_shadow u_shadow (
        .clk     (clk),
        .rst     (rst),
        .capture (snap_take),
        .live    (live_q[SHADOW_FIELDS-1:0]),
        .held    (shadow_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= RESET_TIME;
            ctrl_q <= '0;
            snap_q <= 1'b0;
        end else begin
            snap_q <= wr_ctrl && bus_wdata[CB_SNAP];
            if (wr_ctrl) ctrl_q <= bus_wdata & CTRL_KEEP;
            if (wr_time) begin
                for (int i = 0; i < NUM_FIELDS; i++)
                    if (bus_addr == reg_addr_t'(i)) live_q[i] <= bus_wdata;
            end else begin
                live_q <= live_nxt;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < SHADOW_FIELDS; i++)
            if (bus_addr == reg_addr_t'(i)) bus_rdata = shadow_q[i];
        for (int i = SHADOW_FIELDS; i < NUM_FIELDS; i++)
            if (bus_addr == reg_addr_t'(i)) bus_rdata = live_q[i];
        if (bus_addr == A_CTRL) begin
            bus_rdata          = ctrl_q;
            bus_rdata[CB_SNAP] = snap_q;
        end
        if (bus_addr == A_STAT) bus_rdata[SB_RUN] = ctrl_q[CB_RUN];
    end

endmodule

// File: rtl/bcd_rtc_chk.sv
module bcd_rtc_chk
    import bcd_rtc_pkg::*;
(
    input logic                                  clk,
    input logic                                  rst,
    input logic                                  tick_1s,
    input logic                                  bus_we,
    input logic [REG_ADDR_W-1:0]                 bus_addr,
    input logic                                  snap_bit,
    input logic                                  run_bit,
    input logic                                  h12_bit,
    input time_bytes_t                           live,
    input logic [SHADOW_FIELDS-1:0][FIELD_W-1:0] held
);

    logic step;
    assign step = run_bit && tick_1s && !bus_we;

    // R3
    stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run_bit && !bus_we) |=> $stable(live));

    // R9
    shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && bus_addr == A_CTRL && snap_bit) |=> $stable(held));

    // R4
    sec_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (step && live[0] == 8'h59) |=> (live[0] == 8'h00));

    // R5
    noon_roll_chk: assert property (@(posedge clk) disable iff (rst)
        (step && h12_bit && live[0] == 8'h59 && live[1] == 8'h59 && live[2] == 8'h11)
        |=> (live[2] == 8'h92));

    // R7
    year_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !h12_bit && live[0] == 8'h59 && live[1] == 8'h59 && live[2] == 8'h23 &&
         live[3] == 8'h31 && live[4] == 8'h12 && live[5] == 8'h99)
        |=> (live[5] == 8'h00 && live[4] == 8'h01 && live[3] == 8'h01));

endmodule

bind bcd_rtc_core bcd_rtc_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick_1s  (tick_1s),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .snap_bit (bus_wdata[bcd_rtc_pkg::CB_SNAP]),
    .run_bit  (ctrl_q[bcd_rtc_pkg::CB_RUN]),
    .h12_bit  (ctrl_q[bcd_rtc_pkg::CB_H12]),
    .live     (live_q),
    .held     (shadow_q)
);

// File: tb/tb_bcd_rtc_core.sv
module tb_bcd_rtc_core;
    import bcd_rtc_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [4:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       we = 1'b0;
    logic [7:0] rdata;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 0;

    // binary reference calendar
    int ms, mm, mh, md, mmo, my, mw;
    bit m12;
    logic [7:0] ctl = 8'h00;
    logic [7:0] rv;
    logic [7:0] old_sec;

    always #(CLK_PERIOD/2) clk = ~clk;

    bcd_rtc_core dut (
        .clk(clk), .rst(rst), .tick_1s(tick), .bus_addr(addr),
        .bus_wdata(wdata), .bus_we(we), .bus_rdata(rdata)
    );

    function automatic logic [7:0] to_bcd(int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic int dim(int mo, int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic logic [7:0] hour_byte(int h, bit mode12);
        logic [7:0] b;
        int hv;
        if (!mode12) return to_bcd(h);
        hv = (h % 12 == 0) ? 12 : h % 12;
        b = to_bcd(hv);
        b[7] = (h >= 12);
        return b;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_minute();
        mm++;
        if (mm == 60) begin
            mm = 0; mh++;
            if (mh == 24) begin
                mh = 0; mw = (mw + 1) % 7; md++;
                if (md > dim(mmo, my)) begin
                    md = 1; mmo++;
                    if (mmo == 13) begin mmo = 1; my = (my + 1) % 100; end
                end
            end
        end
    endtask

    task automatic model_tick();
        ms++;
        if (ms == 60) begin ms = 0; model_minute(); end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; we = 1'b1;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        addr = a; #1; d = rdata;
    endtask

    task automatic tk(input int n);
        repeat (n) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
            if (ctl[0]) model_tick();
        end
    endtask

    task automatic set_time(input int y, input int mo, input int d, input int h,
                            input int mi, input int s, input int wd, input bit mode12);
        ms = s; mm = mi; mh = h; md = d; mmo = mo; my = y; mw = wd; m12 = mode12;
        wr(A_CTRL, mode12 ? 8'h08 : 8'h00);
        wr(5'h00, to_bcd(s));
        wr(5'h01, to_bcd(mi));
        wr(5'h02, hour_byte(h, mode12));
        wr(5'h03, to_bcd(d));
        wr(5'h04, to_bcd(mo));
        wr(5'h05, to_bcd(y));
        wr(5'h06, to_bcd(wd));
        ctl = mode12 ? 8'h09 : 8'h01;
        wr(A_CTRL, ctl);
    endtask

    task automatic check_all(input string tag);
        wr(A_CTRL, ctl | 8'h40);
        rd(5'h00, rv); chk({tag, " sec"},  rv, to_bcd(ms));
        rd(5'h01, rv); chk({tag, " min"},  rv, to_bcd(mm));
        rd(5'h02, rv); chk({tag, " hour"}, rv, hour_byte(mh, m12));
        rd(5'h03, rv); chk({tag, " day"},  rv, to_bcd(md));
        rd(5'h04, rv); chk({tag, " mon"},  rv, to_bcd(mo_dummy(mmo)));
        rd(5'h05, rv); chk({tag, " year"}, rv, to_bcd(my));
        rd(5'h06, rv); chk({tag, " wday"}, rv, to_bcd(mw));
    endtask

    function automatic int mo_dummy(int v);
        return v;
    endfunction

    task automatic month_end(input int y, input int mo, input int d, input int wd, input string tag);
        set_time(y, mo, d, 23, 59, 58, wd, 1'b0);
        tk(2);
        check_all(tag);
    endtask

    function automatic int rr(int lo, int hi);
        return lo + int'($urandom % 32'(hi - lo + 1));
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset values
        rd(5'h00, rv); chk("R1 sec", rv, 8'h00);
        rd(5'h01, rv); chk("R1 min", rv, 8'h00);
        rd(5'h02, rv); chk("R1 hour", rv, 8'h00);
        rd(5'h03, rv); chk("R1 day", rv, 8'h01);
        rd(5'h04, rv); chk("R1 mon", rv, 8'h01);
        rd(5'h05, rv); chk("R1 year", rv, 8'h00);
        rd(5'h06, rv); chk("R1 wday", rv, 8'h00);
        rd(A_CTRL, rv); chk("R1 ctrl", rv, 8'h00);
        rd(A_STAT, rv); chk("R1 status", rv, 8'h00);

        // R3 stopped clock ignores ticks, then counts once running
        set_time(42, 7, 15, 10, 20, 30, 3, 1'b0);
        ctl = 8'h00; wr(A_CTRL, ctl);
        rd(A_STAT, rv); chk("R3 status stopped", rv, 8'h00);
        tk(4);
        check_all("R3 stopped");
        ctl = 8'h01; wr(A_CTRL, ctl);
        rd(A_STAT, rv); chk("R3 status running", rv, 8'h02);
        tk(5);
        check_all("R3 running");

        // R2 field write beats a simultaneous tick
        @(negedge clk); addr = 5'h00; wdata = 8'h42; we = 1'b1; tick = 1'b1;
        @(negedge clk); we = 1'b0; tick = 1'b0;
        ms = 42;
        check_all("R2 write vs tick");

        // R4 R6 R7 R8 boundary carries
        month_end(24, 2, 28, 2, "R6 leap feb28");
        month_end(24, 2, 29, 3, "R6 leap feb29");
        month_end(23, 2, 28, 1, "R6 common feb28");
        month_end(0, 2, 28, 0, "R6 year00 feb28");
        month_end(25, 4, 30, 4, "R6 apr30");
        month_end(25, 1, 31, 5, "R4 jan31");
        month_end(99, 12, 31, 6, "R7 R8 year wrap");

        // R5 twelve-hour transitions
        set_time(10, 5, 5, 11, 59, 59, 1, 1'b1);
        tk(1); check_all("R5 noon");
        set_time(10, 5, 5, 12, 59, 59, 1, 1'b1);
        tk(1); check_all("R5 one pm");
        set_time(10, 5, 5, 23, 59, 59, 1, 1'b1);
        tk(1); check_all("R5 midnight");
        tk(3600); check_all("R5 one am");

        // R9 shadow holds after a snapshot
        set_time(30, 3, 3, 3, 3, 3, 3, 1'b0);
        wr(A_CTRL, ctl | 8'h40);
        // R10 bit reads 1 in the following cycle, then 0
        rd(A_CTRL, rv); chk("R10 snap bit high", rv, 8'h41);
        @(negedge clk);
        rd(A_CTRL, rv); chk("R10 snap bit cleared", rv, 8'h01);
        tk(2);
        rd(5'h00, rv); chk("R9 shadow frozen", rv, 8'h03);
        rd(5'h06, rv); chk("R9 weekday live", rv, 8'h03);
        check_all("R9 fresh snapshot");

        // R10 back-to-back snapshot writes capture once
        old_sec = to_bcd(ms);
        @(negedge clk); addr = A_CTRL; wdata = ctl | 8'h40; we = 1'b1; tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        @(negedge clk); we = 1'b0;
        model_tick();
        rd(5'h00, rv); chk("R10 no second capture", rv, old_sec);
        check_all("R10 new capture");

        // R11 rounding
        set_time(50, 6, 10, 8, 15, 45, 2, 1'b0);
        wr(A_CTRL, ctl | 8'h02); ms = 0; model_minute();
        rd(A_CTRL, rv); chk("R11 round bit reads 0", rv, 8'h01);
        check_all("R11 round up");
        set_time(50, 6, 10, 8, 15, 29, 2, 1'b0);
        ctl = 8'h00; wr(A_CTRL, ctl);
        wr(A_CTRL, ctl | 8'h02); ms = 0;
        check_all("R11 round down stopped");
        set_time(50, 6, 30, 23, 59, 45, 2, 1'b0);
        @(negedge clk); addr = A_CTRL; wdata = ctl | 8'h02; we = 1'b1; tick = 1'b1;
        @(negedge clk); we = 1'b0; tick = 1'b0;
        ms = 0; model_minute();
        check_all("R11 round carry drops tick");

        // random calendars near carries, R4 R6 R8
        for (int it = 0; it < 40; it++) begin
            int y, mo, d;
            y  = rr(0, 99);
            mo = rr(1, 12);
            d  = rr(dim(mo, y) - 1, dim(mo, y));
            set_time(y, mo, d, rr(22, 23), rr(58, 59), rr(50, 59), rr(0, 6), bit'(rr(0, 1)));
            tk(rr(1, 15));
            check_all("R4 R6 R8 random");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule